// File: doc/BRIEF.md
# Transmit Jabber Guard with Heartbeat Generator

This block watches the 10 Mb/s transmit path of a twisted-pair transceiver. A frame whose transmit enable stays high for too long is cut off. The transmit gate output closes and stays closed until the transmit enable has been idle without a break for a much longer recovery interval. A status flag records that the cut-off happened. It stays set after the gate reopens, until a clear strobe acknowledges it.

After each normal transmission ends, the block sends a short heartbeat on its collision output. This pulse tests the signal-quality-error path. It begins a fixed number of cycles after carrier sense falls and lasts a fixed number of cycles. No heartbeat is sent when the test is disabled, or when the frame was cut off by the guard.

Both long intervals count millisecond ticks, and a prescaler derives these ticks from the 25 MHz clock. The defaults give about 105 ms to cut off and 406 ms to recover. They also give a heartbeat that starts 0.88 µs after carrier sense falls and lasts 1.0 µs.

Top module: `txj_supervisor`

## Requirements
- R1: While reset is asserted and in the first cycle after it, tx_gate is 1, jab_flag is 0 and col_hb is 0.
- R2: tx_gate goes to 0 after the clock edge at which tx_en has been sampled high for CYC_PER_TICK*JAB_TICKS edges in a row. A sample of tx_en low restarts the count, so shorter runs never close the gate.
- R3: Once closed, tx_gate returns to 1 after the edge at which tx_en has been sampled low for CYC_PER_TICK*UNJAB_TICKS edges in a row. Any sample of tx_en high restarts this count.
- R4: jab_flag becomes 1 at the cut-off and stays 1 while the gate is closed, even when jab_clr is high. After the gate reopens, jab_flag stays 1 until an edge that samples jab_clr high, and then it reads 0.
- R5: Let E0 be the first edge that samples crs low after crs was sampled high. If sqe_en is high at E0, col_hb goes to 1 after edge E0+HB_DLY.
- R6: A heartbeat holds col_hb at 1 for exactly HB_WID cycles.
- R7: If sqe_en is sampled low at E0, no heartbeat follows that carrier fall.
- R8: No heartbeat follows a carrier fall in two cases: the guard cut off transmission since crs last rose, or the gate is closed at E0.
- R9: A new qualifying carrier fall while a heartbeat is pending or active restarts the delay from the new fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable from the MAC |
| crs | input | 1 | Carrier sense |
| sqe_en | input | 1 | Enables the heartbeat test |
| jab_clr | input | 1 | Acknowledge strobe for the sticky cut-off flag |
| tx_gate | output | 1 | 1 lets the transmit path drive the line |
| jab_flag | output | 1 | Sticky cut-off status |
| col_hb | output | 1 | Heartbeat pulse on the collision output |

## Verification
A wrong tick or prescaler count shows up at tx_gate as a cut-off or reopening that comes a whole tick early or late. It is seen one cycle after the edge that should have decided it. A lost abort marker or lost carrier history shows up as a stray or missing col_hb pulse, about HB_DLY cycles after the carrier falls. A sticky flag that clears at the wrong time can be seen on jab_flag one cycle after the jab_clr strobe. The bench runs scaled-down timer parameters, so every interval is checked at its exact boundary cycle.

// File: rtl/txj_pkg.sv
package txj_pkg;
   typedef enum logic [1:0] {
      HB_IDLE  = 2'd0,
      HB_WAIT  = 2'd1,
      HB_PULSE = 2'd2
   } hb_state_t;

   // bits needed to count 0 .. v-1, never below one
   function automatic int cnt_w(input int v);
      return (v < 2) ? 1 : $clog2(v);
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/txj_ms_timer.sv
module txj_ms_timer #(
   parameter int CYC_PER_TICK = 25000,
   parameter int TICK_W       = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [TICK_W-1:0] last_tick,
   output logic              expire
);
   localparam int PRE_W = txj_pkg::cnt_w(CYC_PER_TICK);
   localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_PER_TICK - 1);

   logic [PRE_W-1:0]  pre_q;
   logic [TICK_W-1:0] tick_q;
   logic              pre_wrap;

   assign pre_wrap = (pre_q == PRE_LAST);
   assign expire   = run && pre_wrap && (tick_q == last_tick);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q  <= '0;
         tick_q <= '0;
      end else if (!run || expire) begin
         pre_q  <= '0;
         tick_q <= '0;
      end else if (pre_wrap) begin
         pre_q  <= '0;
         tick_q <= tick_q + 1'b1;
      end else begin
         pre_q  <= pre_q + 1'b1;
      end
   end
endmodule

// File: rtl/txj_jab_ctrl.sv
module txj_jab_ctrl #(
   parameter int CYC_PER_TICK = 25000,
   parameter int JAB_TICKS    = 105,
   parameter int UNJAB_TICKS  = 406
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_en,
   input  logic jab_clr,
   output logic tx_gate,
   output logic jab_flag,
   output logic trip,
   output logic jammed
);
   localparam int TICK_W = txj_pkg::cnt_w(txj_pkg::imax(JAB_TICKS, UNJAB_TICKS));
   localparam logic [TICK_W-1:0] JAB_LAST   = TICK_W'(JAB_TICKS - 1);
   localparam logic [TICK_W-1:0] UNJAB_LAST = TICK_W'(UNJAB_TICKS - 1);

   logic              jammed_q;
   logic              flag_q;
   logic              run;
   logic              expire;
   logic [TICK_W-1:0] last_tick;

   // open: count busy cycles; closed: count idle cycles
   assign run       = tx_en ^ jammed_q;
   assign last_tick = jammed_q ? UNJAB_LAST : JAB_LAST;

   txj_ms_timer #(
      .CYC_PER_TICK (CYC_PER_TICK),
      .TICK_W       (TICK_W)
   ) i_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .last_tick (last_tick),
      .expire    (expire)
   );

   assign trip = expire && !jammed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         jammed_q <= 1'b0;
         flag_q   <= 1'b0;
      end else begin
         if (expire)
            jammed_q <= !jammed_q;
         if (trip || jammed_q)
            flag_q <= 1'b1;
         else if (jab_clr)
            flag_q <= 1'b0;
      end
   end

   assign tx_gate  = !jammed_q;
   assign jab_flag = flag_q;
   assign jammed   = jammed_q;
endmodule

// File: rtl/txj_hb_gen.sv
module txj_hb_gen
   import txj_pkg::*;
#(
   parameter int HB_DLY = 22,
   parameter int HB_WID = 25
) (
   input  logic clk,
   input  logic rst_n,
   input  logic crs,
   input  logic sqe_en,
   input  logic trip,
   input  logic jammed,
   output logic col_hb
);
   localparam int CNT_W = cnt_w(imax(HB_DLY, HB_WID));
   localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(HB_DLY - 1);
   localparam logic [CNT_W-1:0] WID_LAST = CNT_W'(HB_WID - 1);

   hb_state_t        st_q;
   logic [CNT_W-1:0] cnt_q;
   logic             crs_q;
   logic             abort_q;
   logic             fall;
   logic             rise;
   logic             start;

   assign fall  = crs_q && !crs;
   assign rise  = !crs_q && crs;
   assign start = fall && sqe_en && !abort_q && !jammed && !trip;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crs_q   <= 1'b0;
         abort_q <= 1'b0;
         st_q    <= HB_IDLE;
         cnt_q   <= '0;
      end else begin
         crs_q <= crs;
         if (trip)
            abort_q <= 1'b1;
         else if (rise)
            abort_q <= 1'b0;
         if (start) begin
            st_q  <= HB_WAIT;
            cnt_q <= '0;
         end else begin
            unique case (st_q)
               HB_WAIT: begin
                  if (cnt_q == DLY_LAST) begin
                     st_q  <= HB_PULSE;
                     cnt_q <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               HB_PULSE: begin
                  if (cnt_q == WID_LAST) begin
                     st_q  <= HB_IDLE;
                     cnt_q <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               default: begin
                  st_q  <= HB_IDLE;
                  cnt_q <= '0;
               end
            endcase
         end
      end
   end

   assign col_hb = (st_q == HB_PULSE);
endmodule

// File: rtl/txj_supervisor.sv
module txj_supervisor #(
   parameter int CYC_PER_TICK = 25000,
   parameter int JAB_TICKS    = 105,
   parameter int UNJAB_TICKS  = 406,
   parameter int HB_DLY       = 22,
   parameter int HB_WID       = 25,
   parameter bit HAS_SQE      = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_en,
   input  logic crs,
   input  logic sqe_en,
   input  logic jab_clr,
   output logic tx_gate,
   output logic jab_flag,
   output logic col_hb
);
   if (CYC_PER_TICK < 1 || JAB_TICKS < 1 || UNJAB_TICKS < 1) begin : g_bad_timer
      $error("txj_supervisor: timer parameters must be at least 1");
   end
   if (HB_DLY < 1 || HB_WID < 1) begin : g_bad_hb
      $error("txj_supervisor: heartbeat parameters must be at least 1");
   end

   logic trip;
   logic jammed;

   txj_jab_ctrl #(
      .CYC_PER_TICK (CYC_PER_TICK),
      .JAB_TICKS    (JAB_TICKS),
      .UNJAB_TICKS  (UNJAB_TICKS)
   ) i_jab (
      .clk      (clk),
      .rst_n    (rst_n),
      .tx_en    (tx_en),
      .jab_clr  (jab_clr),
      .tx_gate  (tx_gate),
      .jab_flag (jab_flag),
      .trip     (trip),
      .jammed   (jammed)
   );

   if (HAS_SQE) begin : g_sqe
      txj_hb_gen #(
         .HB_DLY (HB_DLY),
         .HB_WID (HB_WID)
      ) i_hb (
         .clk    (clk),
         .rst_n  (rst_n),
         .crs    (crs),
         .sqe_en (sqe_en),
         .trip   (trip),
         .jammed (jammed),
         .col_hb (col_hb)
      );
   end else begin : g_no_sqe
      logic unused_hb;
      assign unused_hb = &{1'b0, crs, sqe_en, trip, jammed};
      assign col_hb = 1'b0;
   end
endmodule

// File: rtl/txj_supervisor_chk.sv
module txj_supervisor_chk #(
   parameter int HB_WID = 25
) (
   input logic clk,
   input logic rst_n,
   input logic tx_en,
   input logic jab_clr,
   input logic tx_gate,
   input logic jab_flag,
   input logic col_hb
);
   int unsigned hb_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hb_run <= 0;
      else
         hb_run <= col_hb ? hb_run + 1 : 0;
   end

   // R2
   trip_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_gate) |-> $past(tx_en));

   // R3
   reopen_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_gate) |-> !$past(tx_en));

   // R4
   gate_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_gate |-> jab_flag);

   // R4
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(jab_flag) |-> ($past(jab_clr) && $past(tx_gate)));

   // R6
   hb_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      col_hb |-> (hb_run < HB_WID));
endmodule

bind txj_supervisor txj_supervisor_chk #(.HB_WID(HB_WID)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tx_en    (tx_en),
   .jab_clr  (jab_clr),
   .tx_gate  (tx_gate),
   .jab_flag (jab_flag),
   .col_hb   (col_hb)
);

// File: tb/test_txj_supervisor.sv
`timescale 1ns/1ps
module test_txj_supervisor;
   localparam int CYC = 4;
   localparam int JAB = 5;
   localparam int UNJ = 30;
   localparam int DLY = 22;
   localparam int WID = 25;
   localparam int L   = CYC * JAB;
   localparam int U   = CYC * UNJ;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_en = 1'b0;
   logic crs = 1'b0;
   logic sqe_en = 1'b1;
   logic jab_clr = 1'b0;
   logic tx_gate, jab_flag, col_hb;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2 clk = !clk;

   txj_supervisor #(
      .CYC_PER_TICK (CYC),
      .JAB_TICKS    (JAB),
      .UNJAB_TICKS  (UNJ),
      .HB_DLY       (DLY),
      .HB_WID       (WID),
      .HAS_SQE      (1'b1)
   ) i_txj_supervisor (
      .clk      (clk),
      .rst_n    (rst_n),
      .tx_en    (tx_en),
      .crs      (crs),
      .sqe_en   (sqe_en),
      .jab_clr  (jab_clr),
      .tx_gate  (tx_gate),
      .jab_flag (jab_flag),
      .col_hb   (col_hb)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- reference model built from the requirements ----------
   int m_cnt, m_dly, m_len;
   bit m_jam, m_flag, m_abort, m_crs_q, m_old_jam, m_enter, m_fall, m_rise, m_start;

   function automatic bit exp_hb();
      return (m_dly == 0) && (m_len > 0);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_dly = 0; m_len = 0;
         m_jam = 0; m_flag = 0; m_abort = 0; m_crs_q = 0;
      end else begin
         m_old_jam = m_jam;
         m_enter   = 0;
         if (!m_jam) begin
            if (tx_en) begin
               m_cnt++;
               if (m_cnt == L) begin m_jam = 1; m_cnt = 0; m_enter = 1; end
            end else m_cnt = 0;
         end else begin
            if (!tx_en) begin
               m_cnt++;
               if (m_cnt == U) begin m_jam = 0; m_cnt = 0; end
            end else m_cnt = 0;
         end
         if (m_enter || m_old_jam) m_flag = 1;
         else if (jab_clr) m_flag = 0;
         m_fall  = m_crs_q && !crs;
         m_rise  = !m_crs_q && crs;
         m_start = m_fall && sqe_en && !m_abort && !m_old_jam && !m_enter;
         if (m_enter) m_abort = 1;
         else if (m_rise) m_abort = 0;
         m_crs_q = crs;
         if (m_start) begin m_dly = DLY; m_len = WID; end
         else if (m_dly > 0) m_dly--;
         else if (m_len > 0) m_len--;
      end
   end

   // cycle-by-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(tx_gate == !m_jam, m_jam ? "R3 gate held closed" : "R2 gate open", tx_gate, !m_jam);
         chk(jab_flag == m_flag, "R4 sticky flag", jab_flag, m_flag);
         chk(col_hb == exp_hb(), "R5 R6 heartbeat timing", col_hb, exp_hb());
      end
   end

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // counts negedges after a carrier drop; returns first high index and width
   task automatic measure_hb(output int first, output int width);
      first = 0; width = 0;
      for (int i = 1; i <= DLY + WID + 6; i++) begin
         @(negedge clk);
         if (col_hb) begin
            if (first == 0) first = i;
            width++;
         end
      end
   endtask

   task automatic frame(input int len);
      tx_en = 1'b1; crs = 1'b1;
      cycles(len);
      tx_en = 1'b0; crs = 1'b0;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      #800000;
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog expired, actual=0 expected=1");
         finish_run();
      end
   end

   initial begin
      int first, width;
      void'($urandom(32'd5150));
      // R1 reset state
      cycles(3);
      chk(tx_gate == 1'b1, "R1 gate in reset", tx_gate, 1);
      chk(jab_flag == 1'b0, "R1 flag in reset", jab_flag, 0);
      chk(col_hb == 1'b0, "R1 hb in reset", col_hb, 0);
      rst_n = 1'b1;
      cycles(1);
      chk(tx_gate && !jab_flag && !col_hb, "R1 after release", {tx_gate, jab_flag, col_hb}, 3'b100);

      // R5 R6 normal heartbeat
      frame(10);
      measure_hb(first, width);
      chk(first == DLY + 1, "R5 heartbeat delay", first, DLY + 1);
      chk(width == WID, "R6 heartbeat width", width, WID);

      // R7 test disabled
      sqe_en = 1'b0;
      frame(12);
      measure_hb(first, width);
      chk(width == 0, "R7 no heartbeat when disabled", width, 0);
      sqe_en = 1'b1;

      // R2 a run one short of the limit, and broken runs
      frame(L - 1);
      cycles(1);
      chk(tx_gate == 1'b1, "R2 one short of limit", tx_gate, 1);
      cycles(DLY + WID + 4);
      tx_en = 1'b1; crs = 1'b1;
      cycles(L - 5);
      tx_en = 1'b0;
      cycles(1);
      tx_en = 1'b1;
      cycles(L - 5);
      tx_en = 1'b0; crs = 1'b0;
      cycles(1);
      chk(tx_gate == 1'b1, "R2 broken run keeps gate open", tx_gate, 1);
      cycles(DLY + WID + 4);

      // R2 R4 R8 jabber cut-off
      tx_en = 1'b1; crs = 1'b1;
      for (int i = 1; i <= L; i++) begin
         @(negedge clk);
         if (i == L - 1) chk(tx_gate == 1'b1, "R2 open before limit", tx_gate, 1);
         if (i == L) begin
            chk(tx_gate == 1'b0, "R2 closed at limit", tx_gate, 0);
            chk(jab_flag == 1'b1, "R4 flag set at cut-off", jab_flag, 1);
         end
      end
      cycles(5);
      tx_en = 1'b0; crs = 1'b0;
      measure_hb(first, width);
      chk(width == 0, "R8 no heartbeat after cut-off", width, 0);

      // R3 restart of recovery; R4 clear ignored while closed
      tx_en = 1'b1;
      cycles(1);
      tx_en = 1'b0; jab_clr = 1'b1;
      for (int i = 1; i <= U; i++) begin
         @(negedge clk);
         if (i == 1) begin
            jab_clr = 1'b0;
            chk(jab_flag == 1'b1, "R4 clear ignored while closed", jab_flag, 1);
         end
         if (i == U - 1) chk(tx_gate == 1'b0, "R3 still closed", tx_gate, 0);
         if (i == U) chk(tx_gate == 1'b1, "R3 reopened after idle", tx_gate, 1);
      end
      cycles(3);
      chk(jab_flag == 1'b1, "R4 flag sticky after reopen", jab_flag, 1);
      jab_clr = 1'b1;
      cycles(1);
      jab_clr = 1'b0;
      chk(jab_flag == 1'b0, "R4 flag cleared", jab_flag, 0);

      // R9 restart of a pending heartbeat
      frame(8);
      cycles(10);
      frame(3);
      measure_hb(first, width);
      chk(first == DLY + 1, "R9 delay restarted by new fall", first, DLY + 1);
      chk(width == WID, "R9 width after restart", width, WID);

      // random traffic, checked every cycle against the model
      for (int b = 0; b < 60; b++) begin
         int len, gap;
         len    = $urandom_range(1, 2 * L);
         gap    = $urandom_range(1, 80);
         sqe_en = ($urandom_range(0, 3) != 0);
         tx_en = 1'b1; crs = 1'b1;
         for (int c = 0; c < len; c++) begin
            tx_en   = ($urandom_range(0, 15) != 0);
            jab_clr = ($urandom_range(0, 9) == 0);
            @(negedge clk);
         end
         tx_en = 1'b0; crs = 1'b0;
         for (int c = 0; c < gap; c++) begin
            jab_clr = ($urandom_range(0, 9) == 0);
            @(negedge clk);
         end
      end
      jab_clr = 1'b0;
      cycles(U + DLY + WID);
      finish_run();
   end
endmodule